// File: doc/BRIEF.md
# Buffered Interrupt Status Controller

This block gathers six event sources into a single active-low interrupt line towards an external master. Each source pulses for one clock when its condition occurs. If the matching bit of the enable byte is set at that moment, the event is recorded as pending. The controller presents one request at a time. While a request is presented it holds `irq_n` low and shows a one-hot status byte on `data_out`. The master reads that byte with a one-cycle `rd_stb` pulse, and the read clears the request. Events that arrive in the meantime wait in a pending set. They are served highest bit first, and a repeat of an event that is already pending is merged into the same entry.

The master can also open a register-read transaction with `rd_req`. From then on, no ordinary status request is presented. When the register side signals `rd_done`, the controller captures `reg_rdata` and raises the interrupt. The next assertion therefore means the read data is ready. The master reads that value with `rd_stb`, which closes the transaction and lets held events through. All pins are plain control and status pins. The master paces the block through the strobe, so there is no valid/ready handshake.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and `data_out` is 0x00. Whenever nothing is presented, `data_out` reads 0x00.
- R2: A presented status byte has exactly one bit set. The bit positions are: SETUP bit 7 (`src_evt[5]`), EP0BUF bit 6 (`src_evt[4]`), FLAGS bit 5 (`src_evt[3]`), ENUMOK bit 4 (`src_evt[2]`), BUSACTIVITY bit 3 (`src_evt[1]`) and READY bit 2 (`src_evt[0]`). Bits 1 and 0 are always 0.
- R3: An event whose enable bit is 0 in the cycle it pulses is discarded. Setting the enable bit later does not raise it.
- R4: Suppose an enabled event is sampled at a rising edge while the controller is idle and no read is open. Then `irq_n` goes low at the next rising edge.
- R5: A `rd_stb` sampled while a request is presented makes `irq_n` high and `data_out` 0x00 after that same edge.
- R6: Only one request is presented at a time. After a read, if another event is pending, `irq_n` goes low again one clock later, leaving exactly one high cycle.
- R7: Among pending events, the one with the highest status bit is presented first.
- R8: A source that pulses again while its event is still pending produces only one presentation.
- R9: After `rd_req`, no status request is presented until the read completes. A `rd_done` captures `reg_rdata`, which is then presented on `data_out` with `irq_n` low. The `rd_stb` that reads it ends the hold.
- R10: An event that arrives in the same cycle as the read of its own presented request is kept, and is presented again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 6 | One-cycle event pulses, index mapping as in R2 |
| irq_en | input | 8 | Enable byte, bit positions as the status byte |
| rd_stb | input | 1 | Master read strobe for the presented byte |
| rd_req | input | 1 | Master opens a register-read transaction |
| rd_done | input | 1 | Register side reports read data valid |
| reg_rdata | input | 8 | Register read data, captured on `rd_done` |
| irq_n | output | 1 | Active-low interrupt to the master |
| data_out | output | 8 | Presented status byte or read data |

## Verification
Two functions can meet in one cycle: the read strobe that retires a presented request, and a new pulse from the same source. The bench drives `rd_stb` and the SETUP pulse in one cycle. It then expects one high cycle on `irq_n`, followed by 0x80 again. A lost or duplicated event would show up as a missing presentation or a second one. A second collision is `rd_req` arriving while events are pending. The expectation is that the status byte stays held until the read-data presentation has been read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    K_IDLE   = 2'd0,
    K_STATUS = 2'd1,
    K_RDDATA = 2'd2
  } pres_kind_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 6,
  parameter int DW   = 8,
  parameter int LSB  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [DW-1:0]   en,
  input  logic [DW-1:0]   clr,
  output logic [DW-1:0]   pend
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= LSB && i < LSB + NSRC) begin : g_src
      localparam int K = i - LSB;
      logic hit;
      assign hit = evt[K] & en[i];
      always_ff @(posedge clk) begin
        if (!rst_n)     pend[i] <= 1'b0;
        else if (hit)   pend[i] <= 1'b1;
        else if (clr[i]) pend[i] <= 1'b0;
      end
      // R4 / R10: an enabled pulse is never lost, even against a clear
      p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[K] && en[i]) |=> pend[i]);
    end else begin : g_rsv
      logic unused_bit;
      assign unused_bit = clr[i] ^ en[i];
      assign pend[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NSRC = 6,
  parameter int DW   = 8,
  parameter int LSB  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic [DW-1:0]   irq_en,
  input  logic            rd_stb,
  input  logic            rd_req,
  input  logic            rd_done,
  input  logic [DW-1:0]   reg_rdata,
  output logic            irq_n,
  output logic [DW-1:0]   data_out
);
  import irq_pkg::*;

  localparam logic [DW-1:0] LO_MASK = DW'((1 << LSB) - 1);

  pres_kind_e    kind_q;
  logic [DW-1:0] pres_q;
  logic [DW-1:0] rdat_q;
  logic          busy_q;
  logic          dr_q;
  logic [DW-1:0] pend;
  logic [DW-1:0] sel;
  logic [DW-1:0] clr;
  logic          sel_go;

  irq_pend_bank #(.NSRC(NSRC), .DW(DW), .LSB(LSB)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (src_evt),
    .en   (irq_en),
    .clr  (clr),
    .pend (pend)
  );

  irq_prio_pick #(.W(DW)) u_pick (
    .vec  (pend),
    .grant(sel)
  );

  assign sel_go = (kind_q == K_IDLE) && !dr_q && !busy_q && !rd_req && (|pend);
  assign clr    = sel_go ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      pres_q <= '0;
      rdat_q <= '0;
      busy_q <= 1'b0;
      dr_q   <= 1'b0;
    end else begin
      if (rd_req && !busy_q) busy_q <= 1'b1;
      if (rd_done && busy_q && !dr_q) begin
        dr_q   <= 1'b1;
        rdat_q <= reg_rdata;
      end
      case (kind_q)
        K_IDLE: begin
          if (dr_q) kind_q <= K_RDDATA;
          else if (sel_go) begin
            kind_q <= K_STATUS;
            pres_q <= sel;
          end
        end
        K_STATUS: if (rd_stb) kind_q <= K_IDLE;
        K_RDDATA: begin
          if (rd_stb) begin
            kind_q <= K_IDLE;
            busy_q <= 1'b0;
            dr_q   <= 1'b0;
          end
        end
        default: kind_q <= K_IDLE;
      endcase
    end
  end

  assign irq_n = (kind_q == K_IDLE);

  always_comb begin
    case (kind_q)
      K_STATUS: data_out = pres_q;
      K_RDDATA: data_out = rdat_q;
      default:  data_out = '0;
    endcase
  end

  logic [DW-1:0] hi_mask;
  assign hi_mask = ~((pres_q << 1) - DW'(1));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_STATUS) |-> ($onehot(data_out) && ((data_out & LO_MASK) == '0)));

  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && rd_stb) |=> irq_n);

  p_highest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_STATUS && $past(kind_q) != K_STATUS) |-> (($past(pend) & hi_mask) == '0));

  p_hold_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_IDLE && busy_q) |=> (kind_q != K_STATUS));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_evt;
  logic [7:0] irq_en;
  logic       rd_stb, rd_req, rd_done;
  logic [7:0] reg_rdata;
  logic       irq_n;
  logic [7:0] data_out;

  int checks = 0;
  int fails  = 0;

  localparam int S_SETUP = 5, S_EP0 = 4, S_FLAGS = 3, S_ENUM = 2, S_BUS = 1, S_RDY = 0;

  always #10 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .irq_en(irq_en),
    .rd_stb(rd_stb), .rd_req(rd_req), .rd_done(rd_done), .reg_rdata(reg_rdata),
    .irq_n(irq_n), .data_out(data_out)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // irq_n in bit 8, data_out below
  task automatic expect_state(input string req, input logic n, input logic [7:0] d);
    chk(req, {irq_n, data_out}, {n, d});
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [5:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic logic [7:0] bit_of(input int s);
    return 8'(1 << (s + 2));
  endfunction

  task automatic t_reset();
    expect_state("R1 reset", 1'b1, 8'h00);
  endtask

  task automatic t_single();
    for (int s = 0; s < 6; s++) begin
      pulse(6'(1 << s));
      expect_state("R4 not yet", 1'b1, 8'h00);
      step(1);
      expect_state("R2 R4 presented", 1'b0, bit_of(s));
      do_read();
      expect_state("R5 cleared", 1'b1, 8'h00);
      step(2);
      expect_state("R1 idle", 1'b1, 8'h00);
    end
  endtask

  task automatic t_disabled();
    irq_en = 8'hFC & ~bit_of(S_FLAGS);
    pulse(6'(1 << S_FLAGS));
    step(3);
    expect_state("R3 disabled ignored", 1'b1, 8'h00);
    irq_en = 8'hFC;
    step(3);
    expect_state("R3 late enable", 1'b1, 8'h00);
  endtask

  task automatic t_priority();
    pulse(6'((1 << S_RDY) | (1 << S_FLAGS) | (1 << S_SETUP)));
    step(1);
    expect_state("R7 first SETUP", 1'b0, 8'h80);
    do_read();
    expect_state("R6 gap", 1'b1, 8'h00);
    step(1);
    expect_state("R6 R7 second FLAGS", 1'b0, 8'h20);
    do_read();
    step(1);
    expect_state("R7 third READY", 1'b0, 8'h04);
    do_read();
    step(2);
    expect_state("R6 drained", 1'b1, 8'h00);
  endtask

  task automatic t_merge();
    pulse(6'(1 << S_EP0));
    step(1);
    expect_state("R8 EP0BUF", 1'b0, 8'h40);
    pulse(6'(1 << S_ENUM));
    step(1);
    pulse(6'(1 << S_ENUM));
    expect_state("R6 single presentation", 1'b0, 8'h40);
    do_read();
    step(1);
    expect_state("R8 ENUMOK once", 1'b0, 8'h10);
    do_read();
    step(3);
    expect_state("R8 no duplicate", 1'b1, 8'h00);
  endtask

  task automatic t_rdhold();
    pulse(6'(1 << S_BUS));
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    step(4);
    expect_state("R9 held", 1'b1, 8'h00);
    reg_rdata = 8'hA5;
    rd_done   = 1'b1;
    @(negedge clk);
    rd_done   = 1'b0;
    reg_rdata = 8'h00;
    step(1);
    expect_state("R9 read data", 1'b0, 8'hA5);
    do_read();
    expect_state("R9 R5 read cleared", 1'b1, 8'h00);
    step(1);
    expect_state("R9 released BUSACTIVITY", 1'b0, 8'h08);
    do_read();
    step(2);
  endtask

  task automatic t_collide();
    pulse(6'(1 << S_SETUP));
    step(1);
    expect_state("R10 SETUP", 1'b0, 8'h80);
    src_evt = 6'(1 << S_SETUP);
    rd_stb  = 1'b1;
    @(negedge clk);
    src_evt = '0;
    rd_stb  = 1'b0;
    expect_state("R10 gap", 1'b1, 8'h00);
    step(1);
    expect_state("R10 kept", 1'b0, 8'h80);
    do_read();
    step(3);
    expect_state("R10 once only", 1'b1, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_evt = '0; irq_en = 8'hFC;
    rd_stb = 1'b0; rd_req = 1'b0; rd_done = 1'b0; reg_rdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_disabled();
    t_priority();
    t_merge();
    t_rdhold();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule